// File: doc/BRIEF.md
# DMA Graceful Stop and Transmit Poll Sequencer

This block watches writes to a three-bit DMA control word and turns them into two kinds of output. The first is a graceful stop for each direction. When software asks a direction to stop, the block either reports completion at once or holds the request until the frame in flight on that direction ends. The second is a periodic poll strobe that tells the transmit descriptor walker to rescan ring 0.

Both completion reports are single-cycle pulses meant for an interrupt event register. The poll timer is restarted by every control write that leaves the hold bit clear, and it is stopped by any write that sets the hold bit. While the transmit stop bit is set, expiries still occur but produce no strobe. The descriptor walker and the event register are outside this block.

The period is the parameter `POLL_CYCLES`, given in clock cycles. At a 50 MHz clock, a rate of 100 polls per second corresponds to 500000 cycles.

Top module: `dma_stop_poll_seq`

## Requirements
- R1: After reset the block produces no completion pulse and no poll strobe, and the poll timer stays idle until the first control write that has the hold bit clear.
- R2: A write with bit 0 (receive stop) set while `rx_frame_busy` is low raises `rx_stop_done` in the cycle right after the write edge.
- R3: A write with bit 0 set while `rx_frame_busy` is high raises no pulse at first; `rx_stop_done` rises in the cycle after the edge that samples `rx_frame_end` high.
- R4: Bit 1 (transmit stop) does the same for the transmit direction, using `tx_frame_busy` and `tx_frame_end` and raising `tx_stop_done`.
- R5: A deferred stop is dropped with no pulse if a later control write clears that direction's stop bit before the frame ends.
- R6: A control write with bit 2 (hold) clear restarts the poll timer, so the first `tx_ring0_poll` strobe appears `POLL_CYCLES` cycles after the write edge. This holds even if the timer was already running.
- R7: While the timer runs, it rearms on every expiry, so strobes repeat every `POLL_CYCLES` cycles. Each strobe lasts one cycle.
- R8: An expiry that occurs while the stored transmit stop bit is set produces no strobe.
- R9: A control write with the hold bit set stops the timer, and no strobe follows until a later write clears the hold bit.
- R10: Each completion pulse is high for exactly one cycle per completed stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr_en | input | 1 | Control word write strobe |
| ctrl_wr_data | input | 3 | Control word: bit 0 receive stop, bit 1 transmit stop, bit 2 poll hold |
| rx_frame_busy | input | 1 | Receive frame in progress |
| tx_frame_busy | input | 1 | Transmit frame in progress |
| rx_frame_end | input | 1 | Receive end-of-frame strobe |
| tx_frame_end | input | 1 | Transmit end-of-frame strobe |
| rx_stop_done | output | 1 | Receive stop complete pulse |
| tx_stop_done | output | 1 | Transmit stop complete pulse |
| tx_ring0_poll | output | 1 | Rescan transmit ring 0 strobe |

## Verification
The bench builds the block with `POLL_CYCLES` = 8. With that value, several consecutive expiries fit within a few dozen cycles. This brings into reach the rearm spacing, a restart issued halfway through a period, suppression of strobes under transmit stop across three periods, and a hold written just before an expiry. Every completion and strobe is compared against the exact cycle predicted from the write and end-of-frame edges.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
  localparam int CTRL_W      = 3;
  localparam int RX_STOP_BIT = 0;
  localparam int TX_STOP_BIT = 1;
  localparam int HOLD_BIT    = 2;
  localparam int NUM_DIR     = 2;
  typedef enum logic [0:0] {DIR_RX = 1'b0, DIR_TX = 1'b1} dir_e;
endpackage

// File: rtl/dsp_stop_track.sv
module dsp_stop_track (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_stop,
  input  logic frame_busy,
  input  logic frame_end,
  output logic stop_done
);
  logic pending_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      stop_done <= 1'b0;
    end else begin
      stop_done <= 1'b0;
      if (wr_en) begin
        if (wr_stop) begin
          if (!frame_busy || frame_end) begin
            stop_done <= 1'b1;
            pending_q <= 1'b0;
          end else begin
            pending_q <= 1'b1;
          end
        end else begin
          // stop bit cleared: a waiting request is dropped silently
          pending_q <= 1'b0;
        end
      end else if (pending_q && frame_end) begin
        stop_done <= 1'b1;
        pending_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dsp_poll_timer.sv
module dsp_poll_timer #(
  parameter int POLL_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_hold,
  input  logic wr_tx_stop,
  output logic tx_stop_lvl,
  output logic poll
);
  localparam int CNT_W = (POLL_CYCLES > 1) ? $clog2(POLL_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(POLL_CYCLES - 1);

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q       <= 1'b0;
      cnt_q       <= '0;
      poll        <= 1'b0;
      tx_stop_lvl <= 1'b0;
    end else begin
      poll <= 1'b0;
      if (wr_en) begin
        tx_stop_lvl <= wr_tx_stop;
        if (!wr_hold) begin
          run_q <= 1'b1;
          cnt_q <= LAST;
        end else begin
          run_q <= 1'b0;
        end
      end else if (run_q) begin
        if (cnt_q == '0) begin
          cnt_q <= LAST;
          poll  <= !tx_stop_lvl;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dma_stop_poll_seq.sv
module dma_stop_poll_seq
  import dsp_pkg::*;
#(
  parameter int POLL_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr_en,
  input  logic [CTRL_W-1:0] ctrl_wr_data,
  input  logic              rx_frame_busy,
  input  logic              tx_frame_busy,
  input  logic              rx_frame_end,
  input  logic              tx_frame_end,
  output logic              rx_stop_done,
  output logic              tx_stop_done,
  output logic              tx_ring0_poll
);
  logic [NUM_DIR-1:0] busy_v, end_v, stop_v, done_v;
  logic               tx_stop_lvl;

  assign busy_v[DIR_RX] = rx_frame_busy;
  assign busy_v[DIR_TX] = tx_frame_busy;
  assign end_v[DIR_RX]  = rx_frame_end;
  assign end_v[DIR_TX]  = tx_frame_end;
  assign stop_v[DIR_RX] = ctrl_wr_data[RX_STOP_BIT];
  assign stop_v[DIR_TX] = ctrl_wr_data[TX_STOP_BIT];

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    dsp_stop_track u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (ctrl_wr_en),
      .wr_stop   (stop_v[d]),
      .frame_busy(busy_v[d]),
      .frame_end (end_v[d]),
      .stop_done (done_v[d])
    );
  end

  assign rx_stop_done = done_v[DIR_RX];
  assign tx_stop_done = done_v[DIR_TX];

  dsp_poll_timer #(.POLL_CYCLES(POLL_CYCLES)) u_poll (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (ctrl_wr_en),
    .wr_hold    (ctrl_wr_data[HOLD_BIT]),
    .wr_tx_stop (ctrl_wr_data[TX_STOP_BIT]),
    .tx_stop_lvl(tx_stop_lvl),
    .poll       (tx_ring0_poll)
  );
endmodule

// File: rtl/dma_stop_poll_seq_chk.sv
module dma_stop_poll_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctrl_wr_en,
  input logic [2:0] ctrl_wr_data,
  input logic       rx_frame_busy,
  input logic       tx_frame_busy,
  input logic       rx_frame_end,
  input logic       tx_frame_end,
  input logic       rx_stop_done,
  input logic       tx_stop_done,
  input logic       tx_ring0_poll,
  input logic       tx_stop_lvl
);
  assert_rx_now_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr_en && ctrl_wr_data[0] && !rx_frame_busy) |=> rx_stop_done);

  assert_rx_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stop_done |-> $past(rx_frame_end || (ctrl_wr_en && ctrl_wr_data[0])));

  assert_tx_now_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr_en && ctrl_wr_data[1] && !tx_frame_busy) |=> tx_stop_done);

  assert_tx_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stop_done |-> $past(tx_frame_end || (ctrl_wr_en && ctrl_wr_data[1])));

  assert_poll_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ring0_poll |=> !tx_ring0_poll);

  assert_poll_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ring0_poll |-> !$past(tx_stop_lvl));

  assert_hold_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr_en && ctrl_wr_data[2]) |=> !tx_ring0_poll);
endmodule

bind dma_stop_poll_seq dma_stop_poll_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_wr_en(ctrl_wr_en), .ctrl_wr_data(ctrl_wr_data),
  .rx_frame_busy(rx_frame_busy), .tx_frame_busy(tx_frame_busy),
  .rx_frame_end(rx_frame_end), .tx_frame_end(tx_frame_end),
  .rx_stop_done(rx_stop_done), .tx_stop_done(tx_stop_done),
  .tx_ring0_poll(tx_ring0_poll), .tx_stop_lvl(tx_stop_lvl)
);

// File: tb/dma_stop_poll_seq_test.sv
module dma_stop_poll_seq_test;
  localparam int P = 8;
  localparam logic [2:0] RXS = 3'b001, TXS = 3'b010, HOLD = 3'b100;

  logic clk = 0, rst_n = 0;
  logic ctrl_wr_en = 0;
  logic [2:0] ctrl_wr_data = '0;
  logic rx_frame_busy = 0, tx_frame_busy = 0, rx_frame_end = 0, tx_frame_end = 0;
  logic rx_stop_done, tx_stop_done, tx_ring0_poll;

  int checks = 0, failures = 0, cyc = 0;
  bit done_run = 0;

  typedef struct { int at; int code; string req; } item_t;
  item_t expq[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dma_stop_poll_seq #(.POLL_CYCLES(P)) uut (.*);

  task automatic expect_ev(input int at, input int code, input string req);
    item_t it;
    it.at = at; it.code = code; it.req = req;
    expq.push_back(it);
  endtask

  task automatic fail(input string req, input string what, input int act, input int exp);
    failures++;
    $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
  endtask

  // monitor: compare each produced event against the queue head
  always @(negedge clk) if (rst_n && !done_run) begin
    logic [2:0] seen;
    seen = {tx_ring0_poll, tx_stop_done, rx_stop_done};
    while (expq.size() > 0 && expq[0].at < cyc) begin
      checks++;
      fail(expq[0].req, "missing event code", -1, expq[0].code);
      void'(expq.pop_front());
    end
    for (int k = 0; k < 3; k++) if (seen[k]) begin
      checks++;
      if (expq.size() == 0) fail("R1", "unexpected event code", k, -1);
      else begin
        item_t it;
        it = expq.pop_front();
        if (it.at != cyc || it.code != k) begin
          fail(it.req, "event cycle", cyc, it.at);
          fail(it.req, "event code", k, it.code);
        end
      end
    end
  end

  // returns the edge number at which the write is taken
  task automatic wr(input logic [2:0] d, output int w);
    @(negedge clk); ctrl_wr_en = 1; ctrl_wr_data = d;
    @(posedge clk); #1 w = cyc;
    @(negedge clk); ctrl_wr_en = 0;
  endtask

  task automatic rx_end(output int e);
    @(negedge clk); rx_frame_end = 1;
    @(posedge clk); #1 e = cyc;
    @(negedge clk); rx_frame_end = 0;
  endtask

  task automatic tx_end(output int e);
    @(negedge clk); tx_frame_end = 1;
    @(posedge clk); #1 e = cyc;
    @(negedge clk); tx_frame_end = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  task automatic wait_cyc(input int c);
    while (cyc < c) @(posedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++; fail("R1", "watchdog expired", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int w, e, w2, w3;
    idle(3);
    @(negedge clk);
    checks++;
    if ({rx_stop_done, tx_stop_done, tx_ring0_poll} != 3'b000)
      fail("R1", "outputs in reset", {rx_stop_done, tx_stop_done, tx_ring0_poll}, 0);
    rst_n = 1;
    idle(3 * P); // R1: no poll before any write

    // R2: receive stop while idle
    wr(RXS | HOLD, w); expect_ev(w, 0, "R2");
    idle(4);
    // R3: deferred until end of frame; R10 single pulse
    rx_frame_busy = 1;
    wr(RXS | HOLD, w); idle(5);
    rx_end(e); expect_ev(e, 0, "R3");
    rx_frame_busy = 0; idle(4);
    // R5: cancellation on receive side
    rx_frame_busy = 1;
    wr(RXS | HOLD, w); idle(2); wr(HOLD, w); idle(2);
    rx_end(e); rx_frame_busy = 0; idle(4);
    // R4: transmit stop idle and deferred
    wr(TXS | HOLD, w); expect_ev(w, 1, "R4");
    idle(3);
    tx_frame_busy = 1;
    wr(TXS | HOLD, w); idle(3);
    tx_end(e); expect_ev(e, 1, "R4");
    // R5: cancellation on transmit side
    wr(TXS | HOLD, w); idle(2); wr(HOLD, w); idle(1);
    tx_end(e); tx_frame_busy = 0; idle(4);

    // R6/R7: start polling and rearm
    wr(3'b000, w);
    expect_ev(w + P, 2, "R6"); expect_ev(w + 2*P, 2, "R7"); expect_ev(w + 3*P, 2, "R7");
    wait_cyc(w + 4*P - 2);
    wr(HOLD, w2);            // R9: stop just before the fourth expiry
    idle(3 * P);

    // R8: transmit stop gates polling, stop completes at once
    wr(TXS, w); expect_ev(w, 1, "R4");
    idle(3 * P + 2);
    // R6: restart, then restart again mid period
    wr(3'b000, w2);
    wait_cyc(w2 + 3);
    wr(3'b000, w3);
    expect_ev(w3 + P, 2, "R6"); expect_ev(w3 + 2*P, 2, "R7");
    wait_cyc(w3 + 2*P + 2);
    wr(HOLD, w);             // R9
    idle(3 * P);

    done_run = 1;
    @(negedge clk);
    checks++;
    if (expq.size() != 0) fail("R7", "events left in queue", expq.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule